// File: doc/BRIEF.md
# Serial Audio Link Output Frame Assembler

This block builds the outgoing frame of a serial audio codec link and shifts it out one bit per bit clock. A frame has thirteen slots. Slot 0 is a 16-bit tag and slots 1 to 12 are 20 bits each, for 256 bit clocks per frame. Slots 1 and 2 carry a codec register command, given as an address word and a data word. Slots 3 to 12 carry 16-bit PCM samples. In ascending slot order they are front left, front right, line DAC 1, center, surround left, surround right, low-frequency effects, line DAC 2, handset DAC and IO control.

Each logical transmit channel has a holding register, which software writes, and a shift register that feeds the link. A slot map steers every PCM slot to one channel or to none. On the first bit of each frame the block looks at how many samples each channel has ready. It hands those samples to that channel's slots, lowest slot first, and encodes the result in the tag. The tag therefore marks only the slots that really carry data. Each channel reports whether it can take another write and whether all of its samples have left the link.

Top module: `aclink_frame_tx`

## Requirements
- R1: A frame is 256 bits, sent MSB first: the 16-bit tag, then slots 1 to 12 of 20 bits each. `ac_sync` is high for exactly the 16 tag bit times, starting with the first bit of the frame.
- R2: Tag bit 15 is the frame-valid bit. It is high exactly when at least one of slots 1 to 12 is valid. Tag bit (15 - s) is the valid bit of slot s, for s = 1 to 12. Tag bits 2 to 0 are zero.
- R3: If `cmd_pend` is high at the clock edge that sends a frame's first bit, slot 1 carries `cmd_addr` and slot 2 carries `cmd_data`, each as a 20-bit word, and both are tagged valid. Otherwise both slots are zero and tagged invalid.
- R4: The map field for slot s sits at `slot_map[2(s-3)+1 : 2(s-3)]`. Value 0 leaves the slot unassigned. Value k (1 or 2) assigns the slot to channel k-1. The map is sampled at the edge that sends a frame's first bit.
- R5: The samples a channel holds at a frame's first edge, at most two, fill the slots assigned to it in ascending slot order, one sample per slot. Each filled slot is tagged valid and carries the sample in bits 19 to 4, with zeros below.
- R6: A slot that is not valid carries twenty zero bits.
- R7: Samples beyond a channel's assigned slots wait for the following frames and go out in the order they were written.
- R8: `tx_rdy[c]` drops in the cycle after an accepted write. It rises again once the holding register has moved into the shift register. A write made while `tx_rdy[c]` is low is ignored.
- R9: `tx_empty[c]` drops in the cycle after an accepted write. It rises only after the edge that ends the last bit time of the channel's last sample.
- R10: During reset, `ac_sdata` and `ac_sync` are low and all `tx_rdy` and `tx_empty` bits are high. The first frame begins on the first clock edge with reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pend | input | 1 | A codec command is pending |
| cmd_addr | input | 20 | Command address word for slot 1 |
| cmd_data | input | 20 | Command data word for slot 2 |
| slot_map | input | 20 | Channel field per PCM slot, 2 bits each, slot 3 lowest |
| wr_en | input | 2 | Per-channel write strobe for the holding register |
| wr_data | input | 32 | Per-channel 16-bit sample, channel 0 lowest |
| tx_rdy | output | 2 | Holding register free |
| tx_empty | output | 2 | Nothing left to send for the channel |
| ac_sync | output | 1 | Frame sync |
| ac_sdata | output | 1 | Serial data |

## Verification
Bit p of a frame, counting from 0, appears on `ac_sdata` after the p-th rising edge that follows the frame's first edge. The bench finds each frame at the falling edge where `ac_sync` first reads high. From there it captures 256 bits on successive falling edges and compares the result with a frame it builds itself from the map, the command and the samples written in the previous frame. The bench reads `tx_rdy` at the falling edge just after a write edge, when it must already be low. It reads `tx_empty` both at the falling edge within the final bit time of slot 12 and one edge later, so that the moment the last bit leaves the link is checked on both sides.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  // fixed frame geometry of the link
  localparam int NSLOT     = 13;
  localparam int PCM_SLOTS = 10;
  typedef logic [3:0] slot_t;
  localparam slot_t FIRST_PCM = 4'd3;
  localparam slot_t LAST_SLOT = 4'd12;
endpackage

// File: rtl/aclink_slot_timer.sv
module aclink_slot_timer
  import aclink_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20
) (
  input  logic  clk,
  input  logic  rst,
  output slot_t slot,
  output logic  slot_start,
  output logic  frame_start
);
  localparam int BW = $clog2(SLOT_W);

  logic [BW-1:0] bitn;
  logic [BW-1:0] last_bit;

  assign last_bit    = (slot == '0) ? BW'(TAG_W - 1) : BW'(SLOT_W - 1);
  assign slot_start  = (bitn == '0);
  assign frame_start = slot_start && (slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      bitn <= '0;
    end else if (bitn == last_bit) begin
      bitn <= '0;
      slot <= (slot == LAST_SLOT) ? '0 : slot + slot_t'(1);
    end else begin
      bitn <= bitn + BW'(1);
    end
  end

  // R1
  slot0_len_chk: assert property (@(posedge clk) disable iff (rst)
    (slot == '0) |-> (bitn < BW'(TAG_W)));
endmodule

// File: rtl/aclink_chan.sv
module aclink_chan #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic              take,
  input  logic              bound,
  output logic [SAMP_W-1:0] shift_data,
  output logic [1:0]        avail,
  output logic              tx_rdy,
  output logic              tx_empty
);
  logic [SAMP_W-1:0] hold_q;
  logic [SAMP_W-1:0] shift_q;
  logic hold_full;
  logic shift_full;
  logic inflight;
  logic shift_free;

  assign shift_free = !shift_full || take;
  assign shift_data = shift_q;
  assign avail      = {1'b0, hold_full} + {1'b0, shift_full};
  assign tx_rdy     = !hold_full;
  assign tx_empty   = !hold_full && !shift_full && !inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      shift_q    <= '0;
      hold_full  <= 1'b0;
      shift_full <= 1'b0;
      inflight   <= 1'b0;
    end else begin
      if (take)       inflight <= 1'b1;
      else if (bound) inflight <= 1'b0;

      if (hold_full && shift_free) begin
        shift_q    <= hold_q;
        shift_full <= 1'b1;
        hold_full  <= 1'b0;
      end else if (take) begin
        shift_full <= 1'b0;
      end

      if (wr_en && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  // R5
  take_full_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> shift_full);
  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_full) |=> $stable(hold_q));
  // R9
  empty_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !tx_empty);
endmodule

// File: rtl/aclink_tag_calc.sv
module aclink_tag_calc
  import aclink_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int MAP_W = 2,
  parameter int TAG_W = 16
) (
  input  logic [NCH*2-1:0]           avail_flat,
  input  logic [PCM_SLOTS*MAP_W-1:0] slot_map,
  input  logic                       cmd_pend,
  output logic [PCM_SLOTS-1:0]       pcm_vld,
  output logic [TAG_W-1:0]           tag
);
  logic [1:0]       seen [NCH];
  logic [MAP_W-1:0] fld;

  always_comb begin
    pcm_vld = '0;
    fld     = '0;
    for (int c = 0; c < NCH; c++) seen[c] = 2'd0;
    for (int s = 0; s < PCM_SLOTS; s++) begin
      fld = slot_map[s*MAP_W +: MAP_W];
      for (int c = 0; c < NCH; c++) begin
        if (fld == MAP_W'(c + 1) && seen[c] < avail_flat[c*2 +: 2]) begin
          pcm_vld[s] = 1'b1;
          seen[c]    = seen[c] + 2'd1;
        end
      end
    end
  end

  always_comb begin
    tag          = '0;
    tag[TAG_W-2] = cmd_pend;
    tag[TAG_W-3] = cmd_pend;
    for (int s = 0; s < PCM_SLOTS; s++) tag[TAG_W-4-s] = pcm_vld[s];
    tag[TAG_W-1] = cmd_pend || (|pcm_vld);
  end
endmodule

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx
  import aclink_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int SAMP_W = 16,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  localparam int MAP_W = $clog2(NCH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_pend,
  input  logic [SLOT_W-1:0]          cmd_addr,
  input  logic [SLOT_W-1:0]          cmd_data,
  input  logic [PCM_SLOTS*MAP_W-1:0] slot_map,
  input  logic [NCH-1:0]             wr_en,
  input  logic [NCH*SAMP_W-1:0]      wr_data,
  output logic [NCH-1:0]             tx_rdy,
  output logic [NCH-1:0]             tx_empty,
  output logic                       ac_sync,
  output logic                       ac_sdata
);
  localparam int PAD_W = SLOT_W - SAMP_W;
  localparam int TPAD  = SLOT_W - TAG_W;

  slot_t slot;
  slot_t idx;
  logic  slot_start;
  logic  frame_start;

  logic [NCH*2-1:0]     avail_flat;
  logic [SAMP_W-1:0]    sh_data [NCH];
  logic [NCH-1:0]       take;
  logic [PCM_SLOTS-1:0] pcm_vld;
  logic [TAG_W-1:0]     tag;

  logic [PCM_SLOTS-1:0]       vld_q;
  logic [PCM_SLOTS*MAP_W-1:0] map_q;
  logic                       cmd_q;
  logic [SLOT_W-1:0]          addr_q;
  logic [SLOT_W-1:0]          data_q;
  logic [SLOT_W-1:0]          shreg;
  logic [SLOT_W-1:0]          word;
  logic [MAP_W-1:0]           fld;
  logic                       sync_q;
  logic                       sdata_q;

  aclink_slot_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .slot(slot),
    .slot_start(slot_start), .frame_start(frame_start)
  );

  aclink_tag_calc #(.NCH(NCH), .MAP_W(MAP_W), .TAG_W(TAG_W)) u_tag (
    .avail_flat(avail_flat), .slot_map(slot_map), .cmd_pend(cmd_pend),
    .pcm_vld(pcm_vld), .tag(tag)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    aclink_chan #(.SAMP_W(SAMP_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[c]), .wr_data(wr_data[c*SAMP_W +: SAMP_W]),
      .take(take[c]), .bound(slot_start),
      .shift_data(sh_data[c]), .avail(avail_flat[c*2 +: 2]),
      .tx_rdy(tx_rdy[c]), .tx_empty(tx_empty[c])
    );
  end

  assign idx = slot - FIRST_PCM;

  always_comb begin
    take = '0;
    word = '0;
    fld  = '0;
    if (slot == '0) begin
      word = {tag, {TPAD{1'b0}}};
    end else if (slot == slot_t'(1)) begin
      word = cmd_q ? addr_q : '0;
    end else if (slot == slot_t'(2)) begin
      word = cmd_q ? data_q : '0;
    end else if (vld_q[idx]) begin
      fld = map_q[idx*MAP_W +: MAP_W];
      for (int c = 0; c < NCH; c++) begin
        if (fld == MAP_W'(c + 1)) begin
          take[c] = slot_start;
          word    = {sh_data[c], {PAD_W{1'b0}}};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      map_q   <= '0;
      cmd_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      shreg   <= '0;
      sync_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      if (frame_start) begin
        vld_q  <= pcm_vld;
        map_q  <= slot_map;
        cmd_q  <= cmd_pend;
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end
      if (slot_start) begin
        sdata_q <= word[SLOT_W-1];
        shreg   <= word << 1;
      end else begin
        sdata_q <= shreg[SLOT_W-1];
        shreg   <= shreg << 1;
      end
      sync_q <= (slot == '0);
    end
  end

  assign ac_sync  = sync_q;
  assign ac_sdata = sdata_q;

  // R5
  take_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_start && slot >= FIRST_PCM && !vld_q[idx]) |=> !ac_sdata);
  // R1
  sync_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_start && slot == slot_t'(1)) |=> !ac_sync);
endmodule

// File: tb/test_aclink_frame_tx.sv
`timescale 1ns/1ps
module test_aclink_frame_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_pend = 1'b0;
  logic [19:0] cmd_addr = '0;
  logic [19:0] cmd_data = '0;
  logic [19:0] slot_map = '0;
  logic [1:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  tx_rdy;
  logic [1:0]  tx_empty;
  logic        ac_sync;
  logic        ac_sdata;

  always #4 clk = ~clk;

  aclink_frame_tx i_aclink_frame_tx (
    .clk(clk), .rst(rst), .cmd_pend(cmd_pend), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .slot_map(slot_map), .wr_en(wr_en),
    .wr_data(wr_data), .tx_rdy(tx_rdy), .tx_empty(tx_empty),
    .ac_sync(ac_sync), .ac_sdata(ac_sdata)
  );

  int checks = 0;
  int errors = 0;
  logic [255:0] cap;
  logic [255:0] exp_f;
  bit           sync_ok;
  logic [1:0]   empty_last;
  logic [15:0]  sa [2][3];

  // {cmd, nB, nA, map}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 2'd0, 2'd0, 20'h00000},
    {1'b1, 2'd0, 2'd0, 20'h00000},
    {1'b0, 2'd1, 2'd1, 20'h00009},
    {1'b1, 2'd2, 2'd2, 20'hAAAA5},
    {1'b0, 2'd1, 2'd2, 20'h42100},
    {1'b0, 2'd1, 2'd2, 20'h99999}
  };

  task automatic chk(input bit ok, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [255:0] build(input logic [19:0] map, input int na,
      input int nb, input bit cmd, input logic [19:0] a, input logic [19:0] d);
    logic [19:0]  w [13];
    logic [15:0]  tg;
    logic [255:0] r;
    int used0, used1, f;
    tg = '0; used0 = 0; used1 = 0;
    for (int s = 0; s < 13; s++) w[s] = '0;
    if (cmd) begin
      w[1] = a; w[2] = d; tg[14] = 1'b1; tg[13] = 1'b1;
    end
    for (int s = 3; s < 13; s++) begin
      f = int'((map >> ((s - 3) * 2)) & 20'h3);
      if (f == 1 && used0 < na) begin
        w[s] = {sa[0][used0], 4'h0}; used0++; tg[15-s] = 1'b1;
      end else if (f == 2 && used1 < nb) begin
        w[s] = {sa[1][used1], 4'h0}; used1++; tg[15-s] = 1'b1;
      end
    end
    tg[15] = |tg[14:3];
    r = '0;
    r[255:240] = tg;
    for (int s = 1; s < 13; s++) r[239-(s-1)*20 -: 20] = w[s];
    return r;
  endfunction

  task automatic wait_frame();
    logic prev;
    prev = ac_sync;
    forever begin
      @(negedge clk);
      if (ac_sync && !prev) break;
      prev = ac_sync;
    end
  endtask

  task automatic capture();
    wait_frame();
    sync_ok = 1'b1;
    cap[255] = ac_sdata;
    for (int p = 1; p < 256; p++) begin
      @(negedge clk);
      cap[255-p] = ac_sdata;
      if (ac_sync != (p < 16)) sync_ok = 1'b0;
      if (p == 255) empty_last = tx_empty;
    end
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    do @(negedge clk); while (!tx_rdy[ch]);
    wr_en[ch] = 1'b1;
    wr_data[ch*16 +: 16] = d;
    @(negedge clk);
    wr_en[ch] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (5) @(negedge clk);
    chk(ac_sdata == 1'b0 && ac_sync == 1'b0, "R10 reset line low",
        256'({ac_sdata, ac_sync}), 256'(0));
    chk(tx_rdy == 2'b11 && tx_empty == 2'b11, "R10 reset flags high",
        256'({tx_rdy, tx_empty}), 256'(4'hF));
    rst = 1'b0;
    @(negedge clk);
    chk(ac_sync == 1'b1 && ac_sdata == 1'b0, "R10 first frame starts",
        256'({ac_sync, ac_sdata}), 256'(2'b10));

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      int na, nb;
      na = int'(VEC[i][21:20]);
      nb = int'(VEC[i][23:22]);
      wait_frame();
      slot_map = VEC[i][19:0];
      cmd_pend = VEC[i][24];
      cmd_addr = 20'hA5C30 ^ 20'(i);
      cmd_data = 20'h3F00F ^ 20'(i << 4);
      for (int k = 0; k < na; k++) begin
        sa[0][k] = 16'h8001 ^ 16'(i * 16'h1357) ^ 16'(k * 16'h0033);
        wr(0, sa[0][k]);
      end
      for (int k = 0; k < nb; k++) begin
        sa[1][k] = 16'h4C02 ^ 16'(i * 16'h0B71) ^ 16'(k * 16'h0055);
        wr(1, sa[1][k]);
      end
      exp_f = build(slot_map, na, nb, cmd_pend, cmd_addr, cmd_data);
      capture();
      chk(cap == exp_f, $sformatf("R2 R3 R4 R5 R6 frame vector %0d", i), cap, exp_f);
      chk(sync_ok, $sformatf("R1 sync window vector %0d", i), 256'(sync_ok), 256'(1));
    end

    // R8 overflow: third write while full is ignored
    wait_frame();
    cmd_pend = 1'b0;
    slot_map = 20'h00015;
    sa[0][0] = 16'h1111; sa[0][1] = 16'h2222; sa[0][2] = 16'h3333;
    wr(0, sa[0][0]);
    chk(tx_rdy[0] == 1'b0, "R8 rdy low after write", 256'(tx_rdy[0]), 256'(0));
    chk(tx_empty[0] == 1'b0, "R9 empty low after write", 256'(tx_empty[0]), 256'(0));
    wr(0, sa[0][1]);
    wr_en[0] = 1'b1;
    wr_data[15:0] = sa[0][2];
    @(negedge clk);
    wr_en[0] = 1'b0;
    chk(tx_rdy[0] == 1'b0, "R8 rdy stays low while full", 256'(tx_rdy[0]), 256'(0));
    exp_f = build(slot_map, 2, 0, 1'b0, cmd_addr, cmd_data);
    capture();
    chk(cap == exp_f, "R8 ignored write absent from frame", cap, exp_f);
    chk(tx_empty == 2'b11, "R9 empty after drain", 256'(tx_empty), 256'(3));

    // R7 spill into the next frame
    wait_frame();
    slot_map = 20'h00001;
    sa[0][0] = 16'hABCD; sa[0][1] = 16'h5A5A;
    wr(0, sa[0][0]);
    wr(0, sa[0][1]);
    exp_f = build(slot_map, 1, 0, 1'b0, cmd_addr, cmd_data);
    capture();
    chk(cap == exp_f, "R7 first frame sends first sample", cap, exp_f);
    sa[0][0] = sa[0][1];
    exp_f = build(slot_map, 1, 0, 1'b0, cmd_addr, cmd_data);
    capture();
    chk(cap == exp_f, "R7 second frame sends second sample", cap, exp_f);

    // R9 empty rises only after the last bit of slot 12
    wait_frame();
    slot_map = 20'h80000;
    sa[1][0] = 16'hF00F;
    wr(1, sa[1][0]);
    chk(tx_empty[1] == 1'b0, "R9 empty low after write ch1", 256'(tx_empty[1]), 256'(0));
    exp_f = build(slot_map, 0, 1, 1'b0, cmd_addr, cmd_data);
    capture();
    chk(cap == exp_f, "R5 slot 12 frame", cap, exp_f);
    chk(empty_last[1] == 1'b0, "R9 empty low during last bit", 256'(empty_last[1]), 256'(0));
    @(negedge clk);
    chk(tx_empty[1] == 1'b1, "R9 empty high after last bit", 256'(tx_empty[1]), 256'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule